// File: doc/BRIEF.md
# Power-Fail Gated Byte-Wide Access Controller

This block sits between a byte-wide asynchronous memory port and an on-chip memory array. It samples active-low chip-enable, output-enable and write-enable strobes, works out which bus operation is in progress, and turns that operation into clean, single-cycle write commands and per-cycle read commands for the array. It also drives the enable for the external data bus.

Two supply-status flags come from external comparators. The first says the supply has fallen below the deselect threshold. While it is set, the port ignores all strobes and keeps its bus driver off. Once it clears, a programmable recovery counter keeps the port deselected for a further number of clock cycles. The second flag says the supply is below the battery switchover threshold. It is passed on, synchronised, as a battery-select output.

Writes are committed only when the write window closes. A supply failure that arrives while a window is still open therefore drops that write completely. No other location is ever touched.

Top module: `pfg_access_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all command outputs, the bus driver enable and the battery select are 0, and the mode output is 0 (deselected).
- R2: With chip enable high, the mode output is 0 (deselected), the bus driver is off and no read or write command is issued, whatever the other strobes do.
- R3: Chip enable low, write enable high and output enable low is a read. The mode output is 2, the bus driver enable is 1, and a read command is issued on every cycle with the read address equal to the bus address. Each of these appears on the third rising clock edge after the strobes settle.
- R4: Chip enable low with both write enable and output enable high gives mode output 3 (outputs disabled). The bus driver is off and no read command is issued.
- R5: Chip enable low with write enable low is a write, and output enable has no effect. The mode output is 1 and the bus driver is off. When the window closes, exactly one single-cycle write command is issued. It carries the address and data that were present at the end of the window, and it appears on the third rising edge after the closing strobe rises.
- R6: A write window closes at whichever of chip enable or write enable rises first. If the other strobe rises later, no second write is issued.
- R7: If write enable falls while a read is driving the bus, the bus driver enable drops on the third rising edge after the fall.
- R8: While the deselect flag is set, no command is issued, the bus driver is off and the mode output is 0, whatever the strobes do.
- R9: If the deselect flag is set while a write window is open, that write is never issued, not even after the strobes are released.
- R10: After the deselect flag clears, and after reset, the port stays deselected for at least `rec_cycles` clock cycles. Strobes are recognised again no later than `rec_cycles` + 5 cycles after the flag clears.
- R11: The battery select output equals the switchover flag delayed by three rising edges, whatever the deselect flag or the strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| bus_addr | input | AW | Byte address from the bus |
| bus_wdata | input | DW | Write data from the bus |
| supply_fail | input | 1 | Comparator flag: supply below deselect threshold |
| supply_low | input | 1 | Comparator flag: supply below battery switchover threshold |
| rec_cycles | input | CW | Recovery hold length in clock cycles |
| bus_drive | output | 1 | Enable for the external data bus driver |
| mem_rd_en | output | 1 | Read command to the array |
| mem_rd_addr | output | AW | Read address |
| mem_wr_en | output | 1 | Single-cycle write command to the array |
| mem_wr_addr | output | AW | Write address |
| mem_wr_data | output | DW | Write data |
| bat_sel | output | 1 | Battery select |
| mode_o | output | 2 | Decoded mode: 0 deselected, 1 write, 2 read, 3 outputs disabled |

## Verification
Every result except the recovery release is due on the third rising edge after its cause: two synchroniser stages and then one output register. The bench drives the strobes just after a falling edge and counts rising edges from there. It samples at the falling edge after exactly three of them, and where latency matters it also samples after two, to show that the old value still holds. The recovery release depends on the counter, so the bench checks a window: deselected two cycles before `rec_cycles` expires, and recognised eight cycles after it. Write commands are also counted on every falling edge, so a duplicated or missing pulse shows up in the count as well as in the cycle where it is expected.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    MODE_DESEL = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_READ  = 2'd2,
    MODE_NOOUT = 2'd3
  } acc_mode_t;
endpackage

// File: rtl/pfg_sync.sv
// Two-stage register chain. Used both as a synchroniser for strobes and
// flags, and as a matching delay for address and data.
module pfg_sync #(
  parameter int W = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[i] <= RST_VAL;
        q[i]      <= RST_VAL;
      end else begin
        stage1[i] <= d[i];
        q[i]      <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/pfg_recover.sv
// Holds the port deselected while the supply is failing, and then for
// `limit` further cycles after the (synchronised) flag clears.
module pfg_recover #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fail_s,
  input  logic [CW-1:0] limit,
  output logic          ready
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || fail_s) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt >= limit) ready <= 1'b1;
      else              cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pfg_access.sv
// Mode decode, write-window tracking and command generation on
// synchronised strobes.
module pfg_access
  import pfg_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic          fail_s,
  input  logic          ready,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] data_a,
  output logic          bus_drive,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output acc_mode_t     mode
);
  logic ok, wr_win, rd_win, noout_win, pend;
  acc_mode_t mode_nx;

  assign ok        = ready & ~fail_s;
  assign wr_win    = ~ce_s & ~we_s;
  assign rd_win    = ~ce_s &  we_s & ~oe_s;
  assign noout_win = ~ce_s &  we_s &  oe_s;

  always_comb begin
    if (!ok)            mode_nx = MODE_DESEL;
    else if (wr_win)    mode_nx = MODE_WRITE;
    else if (rd_win)    mode_nx = MODE_READ;
    else if (noout_win) mode_nx = MODE_NOOUT;
    else                mode_nx = MODE_DESEL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_drive <= 1'b0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      pend      <= 1'b0;
      mode      <= MODE_DESEL;
    end else begin
      mode      <= mode_nx;
      bus_drive <= ok & rd_win;
      rd_en     <= ok & rd_win;
      rd_addr   <= addr_a;
      wr_en     <= 1'b0;
      if (!ok) begin
        pend <= 1'b0;                 // abort any open window
      end else if (wr_win) begin
        pend    <= 1'b1;
        wr_addr <= addr_a;
        wr_data <= data_a;
      end else if (pend) begin
        pend  <= 1'b0;
        wr_en <= 1'b1;                // commit at the closing edge
      end
    end
  end
endmodule

// File: rtl/pfg_access_ctrl.sv
module pfg_access_ctrl
  import pfg_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          supply_fail,
  input  logic          supply_low,
  input  logic [CW-1:0] rec_cycles,
  output logic          bus_drive,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          bat_sel,
  output logic [1:0]    mode_o
);
  localparam int SW = 4;

  logic [SW-1:0] ctl_s;
  logic          low_s, ready;
  logic [AW-1:0] addr_a;
  logic [DW-1:0] data_a;
  acc_mode_t     mode;

  // strobes and fail flag reset to their inactive/safe level
  pfg_sync #(.W(SW), .RST_VAL(1'b1)) u_sync_ctl (
    .clk(clk), .rst(rst),
    .d({supply_fail, we_n, oe_n, ce_n}), .q(ctl_s));

  pfg_sync #(.W(1), .RST_VAL(1'b0)) u_sync_low (
    .clk(clk), .rst(rst), .d(supply_low), .q(low_s));

  pfg_sync #(.W(AW), .RST_VAL(1'b0)) u_dly_addr (
    .clk(clk), .rst(rst), .d(bus_addr), .q(addr_a));

  pfg_sync #(.W(DW), .RST_VAL(1'b0)) u_dly_data (
    .clk(clk), .rst(rst), .d(bus_wdata), .q(data_a));

  pfg_recover #(.CW(CW)) u_rec (
    .clk(clk), .rst(rst), .fail_s(ctl_s[3]), .limit(rec_cycles),
    .ready(ready));

  pfg_access #(.AW(AW), .DW(DW)) u_acc (
    .clk(clk), .rst(rst),
    .ce_s(ctl_s[0]), .oe_s(ctl_s[1]), .we_s(ctl_s[2]), .fail_s(ctl_s[3]),
    .ready(ready), .addr_a(addr_a), .data_a(data_a),
    .bus_drive(bus_drive), .rd_en(mem_rd_en), .rd_addr(mem_rd_addr),
    .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
    .mode(mode));

  always_ff @(posedge clk) begin
    if (rst) bat_sel <= 1'b0;
    else     bat_sel <= low_s;
  end

  assign mode_o = mode;
endmodule

// File: rtl/pfg_access_ctrl_chk.sv
module pfg_access_ctrl_chk #(
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          supply_fail,
  input logic          supply_low,
  input logic [CW-1:0] rec_cycles,
  input logic          bus_drive,
  input logic          mem_rd_en,
  input logic          mem_wr_en,
  input logic          bat_sel,
  input logic [1:0]    mode_o
);
  logic [1:0]  fail_hi;
  logic [1:0]  age;
  logic [CW:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_hi <= '0;
      age     <= '0;
      low_cnt <= '0;
    end else begin
      if (!supply_fail)        fail_hi <= '0;
      else if (fail_hi != 2'd3) fail_hi <= fail_hi + 1'b1;
      if (age != 2'd3) age <= age + 1'b1;
      if (supply_fail) low_cnt <= '0;
      else if (low_cnt <= {1'b0, rec_cycles}) low_cnt <= low_cnt + 1'b1;
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> !mem_wr_en); // R5
  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1) |-> !bus_drive); // R5
  AST_DRIVE_READ: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> (mode_o == 2'd2 && mem_rd_en)); // R3
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (fail_hi == 2'd3) |-> (!bus_drive && !mem_rd_en && !mem_wr_en && mode_o == 2'd0)); // R8
  AST_REC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (low_cnt <= {1'b0, rec_cycles}) |-> (!bus_drive && !mem_rd_en && !mem_wr_en)); // R10
  AST_BAT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (bat_sel == $past(supply_low, 3))); // R11
endmodule

bind pfg_access_ctrl pfg_access_ctrl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .supply_fail(supply_fail), .supply_low(supply_low),
  .rec_cycles(rec_cycles), .bus_drive(bus_drive), .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en), .bat_sel(bat_sel), .mode_o(mode_o));

// File: tb/pfg_access_ctrl_test.sv
`timescale 1ns/1ps
module pfg_access_ctrl_test;
  localparam int AW = 17, DW = 8, CW = 24;
  localparam int REC = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          supply_fail = 1'b0, supply_low = 1'b0;
  logic [CW-1:0] rec_cycles = CW'(REC);
  logic          bus_drive, mem_rd_en, mem_wr_en, bat_sel;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic [1:0]    mode_o;

  int checks = 0, fails = 0, wr_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pfg_access_ctrl #(.AW(AW), .DW(DW), .CW(CW)) uut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .supply_fail(supply_fail),
    .supply_low(supply_low), .rec_cycles(rec_cycles), .bus_drive(bus_drive),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .bat_sel(bat_sel),
    .mode_o(mode_o));

  always @(negedge clk) if (!rst && mem_wr_en) wr_cnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    tick(4);
  endtask

  task automatic t_reset();
    tick(2);
    chk(!bus_drive && !mem_rd_en && !mem_wr_en && !bat_sel, "R1 outputs in reset",
        {bus_drive, mem_rd_en, mem_wr_en, bat_sel}, 0);
    chk(mode_o == 2'd0, "R1 mode in reset", mode_o, 0);
    rst = 1'b0;
    tick(1);
    chk(mode_o == 2'd0 && !bus_drive, "R1 first cycle after reset", mode_o, 0);
    tick(REC + 10);
  endtask

  task automatic t_deselect();
    int w0 = wr_cnt;
    ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b0;
    tick(4);
    chk(mode_o == 2'd0, "R2 mode", mode_o, 0);
    chk(!bus_drive && !mem_rd_en, "R2 no drive/read", {bus_drive, mem_rd_en}, 0);
    we_n = 1'b1; tick(4);
    chk(wr_cnt == w0, "R2 no write", wr_cnt, w0);
  endtask

  task automatic t_read();
    bus_addr = 17'h1ABCD;
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    tick(2);
    chk(!bus_drive, "R3 not before third edge", bus_drive, 0);
    tick(1);
    chk(bus_drive && mem_rd_en, "R3 drive and read", {bus_drive, mem_rd_en}, 3);
    chk(mem_rd_addr == 17'h1ABCD, "R3 read addr", mem_rd_addr, 17'h1ABCD);
    chk(mode_o == 2'd2, "R3 mode", mode_o, 2);
    bus_addr = 17'h00042; tick(3);
    chk(mem_rd_addr == 17'h00042, "R3 read addr follows", mem_rd_addr, 17'h00042);
    oe_n = 1'b1; tick(3);
    chk(mode_o == 2'd3, "R4 mode", mode_o, 3);
    chk(!bus_drive && !mem_rd_en, "R4 no drive", {bus_drive, mem_rd_en}, 0);
    idle();
  endtask

  task automatic t_we_write();
    int w0 = wr_cnt;
    bus_addr = 17'h0F00F; bus_wdata = 8'hA5;
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;   // oe low must be ignored
    tick(3);
    chk(mode_o == 2'd1, "R5 mode", mode_o, 1);
    chk(!bus_drive, "R5 oe ignored", bus_drive, 0);
    we_n = 1'b1; oe_n = 1'b1;
    tick(2);
    chk(!mem_wr_en, "R5 not before third edge", mem_wr_en, 0);
    tick(1);
    chk(mem_wr_en, "R5 pulse", mem_wr_en, 1);
    chk(mem_wr_addr == 17'h0F00F && mem_wr_data == 8'hA5, "R5 addr/data",
        {mem_wr_addr, mem_wr_data}, {17'h0F00F, 8'hA5});
    tick(1);
    chk(!mem_wr_en, "R5 single cycle", mem_wr_en, 0);
    bus_addr = 17'h00001; ce_n = 1'b1; tick(6);
    chk(wr_cnt == w0 + 1, "R6 we-ended one write", wr_cnt, w0 + 1);
  endtask

  task automatic t_ce_write();
    int w0 = wr_cnt;
    bus_addr = 17'h13579; bus_wdata = 8'h3C;
    we_n = 1'b0; tick(2);
    ce_n = 1'b0; tick(5);
    ce_n = 1'b1; tick(3);
    chk(mem_wr_en && mem_wr_addr == 17'h13579 && mem_wr_data == 8'h3C,
        "R6 ce-ended write", {mem_wr_en, mem_wr_addr, mem_wr_data},
        {1'b1, 17'h13579, 8'h3C});
    tick(3);
    we_n = 1'b1; tick(6);
    chk(wr_cnt == w0 + 1, "R6 later we rise no second write", wr_cnt, w0 + 1);
  endtask

  task automatic t_read_to_write();
    int w0 = wr_cnt;
    bus_addr = 17'h00777; bus_wdata = 8'h99;
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; tick(4);
    chk(bus_drive, "R7 read active", bus_drive, 1);
    we_n = 1'b0; tick(2);
    chk(bus_drive, "R7 drive still on after two edges", bus_drive, 1);
    tick(1);
    chk(!bus_drive, "R7 drive off", bus_drive, 0);
    we_n = 1'b1; tick(5);
    chk(wr_cnt == w0 + 1 && bus_drive, "R7 write then read resumes",
        {wr_cnt[3:0], bus_drive}, {4'(w0 + 1), 1'b1});
    idle();
  endtask

  task automatic t_fail_and_recover();
    int w0 = wr_cnt;
    supply_fail = 1'b1;
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; tick(4);
    chk(!bus_drive && !mem_rd_en && mode_o == 2'd0, "R8 read ignored",
        {bus_drive, mem_rd_en, mode_o}, 0);
    we_n = 1'b0; tick(4);
    chk(mode_o == 2'd0, "R8 write mode ignored", mode_o, 0);
    we_n = 1'b1; tick(6);
    chk(wr_cnt == w0, "R8 no write", wr_cnt, w0);
    supply_fail = 1'b0;                    // read strobes still held
    tick(REC - 2);
    chk(!bus_drive, "R10 still held", bus_drive, 0);
    tick(10);
    chk(bus_drive && mode_o == 2'd2, "R10 released", {bus_drive, mode_o}, 3'b110);
    idle();
  endtask

  task automatic t_abort();
    int w0 = wr_cnt;
    bus_addr = 17'h0AAAA; bus_wdata = 8'h55;
    ce_n = 1'b0; we_n = 1'b0; tick(5);
    supply_fail = 1'b1; tick(5);
    ce_n = 1'b1; we_n = 1'b1; tick(6);
    supply_fail = 1'b0; tick(REC + 10);
    chk(wr_cnt == w0, "R9 aborted write never issued", wr_cnt, w0);
  endtask

  task automatic t_battery();
    supply_low = 1'b1; tick(2);
    chk(!bat_sel, "R11 not before third edge", bat_sel, 0);
    tick(1);
    chk(bat_sel, "R11 asserted", bat_sel, 1);
    supply_fail = 1'b1; tick(4);
    chk(bat_sel, "R11 independent of fail", bat_sel, 1);
    supply_low = 1'b0; tick(3);
    chk(!bat_sel, "R11 released", bat_sel, 0);
    supply_fail = 1'b0; tick(REC + 10);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_deselect();
    t_read();
    t_we_write();
    t_ce_write();
    t_read_to_write();
    t_fail_and_recover();
    t_abort();
    t_battery();
    done = 1;
    finish_run();
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule